// File: doc/BRIEF.md
# Sequenced Program ROM

This block is a 128-word by 20-bit program memory that keeps its own program counter. The counter is 10 bits wide and changes once per word frame. At that point it can stay put, step up, step down, go to zero, take an external address, or do a conditional jump. The conditional jump takes the external address when a condition input is true and steps up otherwise. The word at the new address is streamed out one bit per clock, least significant bit first, over the following frame. A separate pin carries an odd parity bit in the bit time after the last data bit. A frame marker shows where each word starts.

Up to eight units can share one set of control, address and condition wires, which gives a 1024-word program space. Every unit steps its own copy of the counter in lockstep with the others. The top three counter bits name a unit, and each unit compares them with a 3-bit strap input. Only the unit whose strap matches drives its data and parity pins; every other unit holds them low, so the pins of all units can be ORed onto a shared line. The contents come from a parameter image that is computed when the design is built. The block does not decode instructions.

Top module: `prog_rom_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `ser_dout`, `par_dout` and `frame_sync` are 0. Reset clears the counter to 0. `frame_sync` is first high in the second cycle after `rst` falls. With `pc_op` = 000 at the first frame edge, the first frame carries the word at address 0.
- R2: A frame is 21 cycles long. `frame_sync` is high in cycle 0 of each frame only. Cycles 0 to 19 carry word bits 0 to 19 on `ser_dout`, least significant bit first.
- R3: In cycle 20, `par_dout` is the inverted XOR of the 20 word bits (odd parity) and `ser_dout` is 0. In cycles 0 to 19, `par_dout` is 0.
- R4: `pc_op`, `ext_addr`, `jmp_cond` and `unit_id` are sampled only at the clock edge that ends cycle 19 of a frame. The word at the resulting address is streamed in the next frame. Values present at any other edge have no effect.
- R5: `pc_op` 000 holds the counter. `pc_op` 001 adds one.
- R6: `pc_op` 010 subtracts one. The counter wraps from 0 to 1023.
- R7: `pc_op` 011 clears the counter to 0.
- R8: `pc_op` 100 loads `ext_addr` into the counter (random access).
- R9: `pc_op` 101 loads `ext_addr` when `jmp_cond` is 1 and adds one when it is 0.
- R10: Counter bits 9:7 are compared with `unit_id`. On a mismatch, `ser_dout` and `par_dout` stay 0 for the whole frame while `frame_sync` keeps running. On a match, the unit streams the word at local address bits 6:0.
- R11: `pc_op` codes 110 and 111 hold the counter. With the default key, the word at local address a is ((a*0x0B5A3 + 0x3C1E5) XOR (a<<11)) mod 2^20.
- R12: `pc_op` 001 wraps the counter from 1023 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bit time per cycle |
| rst | input | 1 | Synchronous active-high reset |
| pc_op | input | 3 | Counter control code |
| ext_addr | input | 10 | Jump or load address |
| jmp_cond | input | 1 | Condition for the conditional jump |
| unit_id | input | 3 | Strap that identifies this unit in a cascade |
| ser_dout | output | 1 | Serial word data, least significant bit first |
| par_dout | output | 1 | Odd parity bit, valid in cycle 20 |
| frame_sync | output | 1 | High in the cycle that carries bit 0 |

## Verification
The bench steps down from address 0 and up from address 1023. A design that drops the 10-bit wrap would stream the wrong word or select the wrong unit.

It selects with one strap value and then with another. A unit that decodes its select bits too late, or not at all, would drive data or parity while unselected.

It pulses a clear code in the middle of a frame that was set up to load. This catches a counter that samples its controls at more than one edge per frame.

It also checks parity against words of varied weight, and unused codes against hold. A design with even parity, or with parity in the wrong slot, would fail these checks.

// File: rtl/prog_rom_pkg.sv
package prog_rom_pkg;
  // Counter control codes; codes 110 and 111 act as hold.
  typedef enum logic [2:0] {
    PC_HOLD = 3'd0,
    PC_INC  = 3'd1,
    PC_DEC  = 3'd2,
    PC_CLR  = 3'd3,
    PC_LOAD = 3'd4,
    PC_CJMP = 3'd5
  } pc_op_e;
endpackage

// File: rtl/prog_rom_pc.sv
module prog_rom_pc #(
  parameter int PC_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step,
  input  logic [2:0]      op,
  input  logic [PC_W-1:0] ext_addr,
  input  logic            cond,
  output logic [PC_W-1:0] pc_q,
  output logic [PC_W-1:0] pc_nxt
);
  import prog_rom_pkg::*;

  localparam logic [PC_W-1:0] ONE = PC_W'(1);

  always_comb begin
    case (op)
      PC_INC:  pc_nxt = pc_q + ONE;
      PC_DEC:  pc_nxt = pc_q - ONE;
      PC_CLR:  pc_nxt = '0;
      PC_LOAD: pc_nxt = ext_addr;
      PC_CJMP: pc_nxt = cond ? ext_addr : pc_q + ONE;
      default: pc_nxt = pc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       pc_q <= '0;
    else if (step) pc_q <= pc_nxt;
  end
endmodule

// File: rtl/prog_rom_mem.sv
module prog_rom_mem #(
  parameter int WORD_W = 20,
  parameter int AW     = 7,
  parameter int DEPTH  = 1 << AW,
  parameter logic [DEPTH*WORD_W-1:0] IMAGE = '0
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign rom[i] = IMAGE[i*WORD_W +: WORD_W];
  end

  // Registered read with enable, no reset: maps onto a block RAM port.
  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= rom[rd_addr];
  end
endmodule

// File: rtl/prog_rom_ser.sv
module prog_rom_ser #(
  parameter int WORD_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word,
  input  logic              sel,
  output logic              boundary,
  output logic              ser_dout,
  output logic              par_dout,
  output logic              frame_sync
);
  localparam int SLOT_W = $clog2(WORD_W + 1);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(WORD_W);

  logic [SLOT_W-1:0] slot;

  assign boundary = (slot == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot       <= LAST;
      ser_dout   <= 1'b0;
      par_dout   <= 1'b0;
      frame_sync <= 1'b0;
    end else begin
      slot       <= boundary ? '0 : slot + SLOT_W'(1);
      frame_sync <= (slot == '0);
      if (boundary) begin
        ser_dout <= 1'b0;
        par_dout <= sel & ~(^word);
      end else begin
        ser_dout <= sel & word[slot];
        par_dout <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/prog_rom_seq.sv
module prog_rom_seq #(
  parameter int          WORD_W   = 20,
  parameter int          LOCAL_AW = 7,
  parameter int          SEL_W    = 3,
  parameter int unsigned IMG_KEY  = 32'h3C1E5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [2:0]                pc_op,
  input  logic [SEL_W+LOCAL_AW-1:0] ext_addr,
  input  logic                      jmp_cond,
  input  logic [SEL_W-1:0]          unit_id,
  output logic                      ser_dout,
  output logic                      par_dout,
  output logic                      frame_sync
);
  localparam int PC_W  = SEL_W + LOCAL_AW;
  localparam int DEPTH = 1 << LOCAL_AW;

  function automatic logic [DEPTH*WORD_W-1:0] fill_image();
    logic [DEPTH*WORD_W-1:0] img;
    logic [WORD_W-1:0]       w;
    img = '0;
    for (int i = 0; i < DEPTH; i++) begin
      w = WORD_W'(i * 32'h0B5A3) + WORD_W'(IMG_KEY);
      w = w ^ WORD_W'(i << 11);
      img[i*WORD_W +: WORD_W] = w;
    end
    return img;
  endfunction

  localparam logic [DEPTH*WORD_W-1:0] IMAGE = fill_image();

  logic              boundary;
  logic [PC_W-1:0]   pc_q;
  logic [PC_W-1:0]   pc_nxt;
  logic [WORD_W-1:0] word_q;
  logic              sel_q;

  prog_rom_pc #(.PC_W(PC_W)) u_pc (
    .clk(clk), .rst(rst), .step(boundary), .op(pc_op),
    .ext_addr(ext_addr), .cond(jmp_cond), .pc_q(pc_q), .pc_nxt(pc_nxt)
  );

  prog_rom_mem #(.WORD_W(WORD_W), .AW(LOCAL_AW), .DEPTH(DEPTH), .IMAGE(IMAGE)) u_mem (
    .clk(clk), .rd_en(boundary), .rd_addr(pc_nxt[LOCAL_AW-1:0]), .rd_data(word_q)
  );

  // Unit select follows the new counter value at each frame edge.
  always_ff @(posedge clk) begin
    if (rst)           sel_q <= 1'b0;
    else if (boundary) sel_q <= (pc_nxt[PC_W-1 -: SEL_W] == unit_id);
  end

  prog_rom_ser #(.WORD_W(WORD_W)) u_ser (
    .clk(clk), .rst(rst), .word(word_q), .sel(sel_q), .boundary(boundary),
    .ser_dout(ser_dout), .par_dout(par_dout), .frame_sync(frame_sync)
  );
endmodule

// File: rtl/prog_rom_seq_chk.sv
module prog_rom_seq_chk #(
  parameter int PC_W   = 10,
  parameter int WORD_W = 20
) (
  input logic            clk,
  input logic            rst,
  input logic            boundary,
  input logic [PC_W-1:0] pc_q,
  input logic [2:0]      pc_op,
  input logic [PC_W-1:0] ext_addr,
  input logic            jmp_cond,
  input logic            sel_q,
  input logic            ser_dout,
  input logic            par_dout,
  input logic            frame_sync
);
  localparam int CW = $clog2(WORD_W + 3);

  logic [CW-1:0] since_fs;
  logic          seen_fs;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_fs <= '0;
      seen_fs  <= 1'b0;
    end else begin
      if (frame_sync) begin
        since_fs <= CW'(1);
        seen_fs  <= 1'b1;
      end else if (since_fs != CW'(WORD_W + 2)) begin
        since_fs <= since_fs + CW'(1);
      end
    end
  end

  // R2
  frame_period_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_sync && seen_fs) |-> (since_fs == CW'(WORD_W + 1)));

  // R3
  par_slot_chk: assert property (@(posedge clk) disable iff (rst)
    par_dout |-> (seen_fs && !frame_sync && since_fs == CW'(WORD_W)));

  // R3
  ser_par_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(ser_dout && par_dout));

  // R4
  pc_steady_chk: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> $stable(pc_q));

  // R7
  pc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (boundary && pc_op == 3'd3) |=> (pc_q == '0));

  // R8
  pc_load_chk: assert property (@(posedge clk) disable iff (rst)
    (boundary && pc_op == 3'd4) |=> (pc_q == $past(ext_addr)));

  // R9
  pc_cjmp_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (boundary && pc_op == 3'd5 && !jmp_cond) |=> (pc_q == PC_W'($past(pc_q) + 1'b1)));

  // R10
  unsel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !sel_q |=> (!ser_dout && !par_dout));
endmodule

bind prog_rom_seq prog_rom_seq_chk #(.PC_W(PC_W), .WORD_W(WORD_W)) chk_i (
  .clk(clk), .rst(rst), .boundary(boundary), .pc_q(pc_q), .pc_op(pc_op),
  .ext_addr(ext_addr), .jmp_cond(jmp_cond), .sel_q(sel_q),
  .ser_dout(ser_dout), .par_dout(par_dout), .frame_sync(frame_sync)
);

// File: tb/prog_rom_seq_tb_top.sv
`timescale 1ns/1ps
module prog_rom_seq_tb_top;
  localparam int          W   = 20;
  localparam int unsigned KEY = 32'h3C1E5;

  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] pc_op;
  logic [9:0] ext_addr;
  logic       jmp_cond;
  logic [2:0] unit_id;
  logic       ser_dout, par_dout, frame_sync;

  int checks = 0;
  int fails  = 0;

  logic [9:0] m_pc;
  logic       m_sel;
  string      pend_tag;

  always #2 clk = ~clk;

  prog_rom_seq #(.IMG_KEY(KEY)) dut_i (
    .clk(clk), .rst(rst), .pc_op(pc_op), .ext_addr(ext_addr), .jmp_cond(jmp_cond),
    .unit_id(unit_id), .ser_dout(ser_dout), .par_dout(par_dout), .frame_sync(frame_sync)
  );

  // Content rule of R11
  function automatic logic [W-1:0] img(input logic [6:0] a);
    logic [W-1:0] r;
    r = W'(32'(a) * 32'h0B5A3) + W'(KEY);
    r = r ^ W'(32'(a) << 11);
    return r;
  endfunction

  function automatic logic [9:0] next_pc(input logic [9:0] pc, input logic [2:0] op,
                                          input logic [9:0] ea, input logic c);
    case (op)
      3'd1: return pc + 10'd1;
      3'd2: return pc - 10'd1;
      3'd3: return 10'd0;
      3'd4: return ea;
      3'd5: return c ? ea : pc + 10'd1;
      default: return pc;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Called at the falling edge of the cycle with frame_sync high.
  task automatic do_frame(input logic [2:0] op, input logic [9:0] ea, input logic c,
                          input logic [2:0] uid, input bit glitch, input string tag);
    logic [W-1:0] got, expw;
    logic         expp, bad;
    expw = m_sel ? img(m_pc[6:0]) : '0;
    expp = m_sel ? ~(^img(m_pc[6:0])) : 1'b0;
    chk(frame_sync === 1'b1, "R2 frame start", 32'(frame_sync), 32'd1);
    pc_op = op; ext_addr = ea; jmp_cond = c; unit_id = uid;
    got = '0;
    got[0] = ser_dout;
    bad = par_dout;
    for (int i = 1; i < W; i++) begin
      @(negedge clk);
      got[i] = ser_dout;
      bad = bad | par_dout | frame_sync;
      if (glitch && i == 9)  begin pc_op = 3'd3; ext_addr = ~ea; jmp_cond = ~c; unit_id = ~uid; end
      if (glitch && i == 10) begin pc_op = op; ext_addr = ea; jmp_cond = c; unit_id = uid; end
    end
    @(negedge clk);
    bad = bad | ser_dout | frame_sync;
    chk(!bad, "R2/R3 idle slots", 32'(bad), 32'd0);
    chk(par_dout === expp, "R3 parity", 32'(par_dout), 32'(expp));
    chk(got === expw, pend_tag, 32'(got), 32'(expw));
    m_pc  = next_pc(m_pc, op, ea, c);
    m_sel = (m_pc[9:7] == uid);
    pend_tag = tag;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    rst = 1'b1; pc_op = 3'd0; ext_addr = '0; jmp_cond = 1'b0; unit_id = 3'd0;
    repeat (3) @(negedge clk);
    chk({ser_dout, par_dout, frame_sync} === 3'b000, "R1 in reset", 32'({ser_dout, par_dout, frame_sync}), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk({ser_dout, par_dout, frame_sync} === 3'b000, "R1 first cycle", 32'({ser_dout, par_dout, frame_sync}), 32'd0);
    @(negedge clk);
    chk(frame_sync === 1'b1, "R1 first frame_sync", 32'(frame_sync), 32'd1);
    m_pc = 10'd0; m_sel = 1'b1; pend_tag = "R1 word 0";

    do_frame(3'd1, 10'h3FF, 1'b1, 3'd0, 1'b0, "R5 inc");
    do_frame(3'd0, 10'h2AA, 1'b1, 3'd0, 1'b0, "R5 hold");
    do_frame(3'd4, 10'h055, 1'b0, 3'd0, 1'b0, "R8 load");
    do_frame(3'd5, 10'h3C0, 1'b0, 3'd0, 1'b0, "R9 cjmp not taken");
    do_frame(3'd5, 10'h07F, 1'b1, 3'd0, 1'b0, "R9 cjmp taken");
    do_frame(3'd2, 10'h000, 1'b0, 3'd0, 1'b0, "R6 dec");
    do_frame(3'd3, 10'h1FF, 1'b1, 3'd0, 1'b0, "R7 clear");
    do_frame(3'd2, 10'h000, 1'b0, 3'd7, 1'b0, "R6 dec wrap to 1023");
    do_frame(3'd1, 10'h000, 1'b0, 3'd7, 1'b0, "R12 inc wrap to 0, R10 unselected");
    do_frame(3'd6, 10'h3FF, 1'b1, 3'd0, 1'b0, "R11 code 110 holds");
    do_frame(3'd7, 10'h3FF, 1'b1, 3'd0, 1'b0, "R11 code 111 holds");
    do_frame(3'd4, 10'(5*128+17), 1'b0, 3'd5, 1'b0, "R10 selected unit 5");
    do_frame(3'd4, 10'(5*128+17), 1'b0, 3'd2, 1'b0, "R10 unit 2 silent");
    do_frame(3'd4, 10'h123, 1'b0, 3'd2, 1'b1, "R4 mid-frame glitch ignored");
    do_frame(3'd0, 10'h000, 1'b0, 3'd2, 1'b0, "R5 hold after load");

    for (int n = 0; n < 400; n++) begin
      logic [2:0] op, uid;
      logic [9:0] ea;
      logic       c;
      op  = 3'($urandom % 8);
      ea  = 10'($urandom);
      c   = 1'($urandom);
      uid = ($urandom % 2 == 0) ? next_pc(m_pc, op, ea, c) >> 7 : 3'($urandom);
      do_frame(op, ea, c, uid, ($urandom % 10) == 0, "R11 random mix");
    end
    do_frame(3'd0, 10'h000, 1'b0, 3'd0, 1'b0, "R5 final hold");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule